// File: doc/BRIEF.md
# SPI Configuration Status Poller

This block polls the status byte of a target device that is being configured over SPI, on behalf of a host sequencer. The host hands it a request carrying a bit mask. The poller then takes status samples over a byte-level SPI transfer handshake until one of three things happens: the target reports not-busy with every mask bit set, the target reports an error, or a cycle-count timeout expires. The bit-level shifter sits outside this block. It is seen only as a byte-transfer port: a one-cycle launch with the byte to send, and later a one-cycle completion with the byte received.

Every status sample is taken as a pair of identical one-byte transfers. Chip select is released between them. The reply to the first transfer is unreliable, so it is thrown away and only the reply to the second is judged. If a sample does not end the poll, the next sample is launched at once. The result port reports the last judged status byte, together with a one-cycle done strobe. Two qualifier strobes ride on done: one for an I/O error and one for a timeout.

Top module: `cfg_status_poller`

## Requirements
- R1: Every SPI transfer the block launches sends the status opcode 0x00.
- R2: A status sample is two transfers. Chip select (active low) is low from each launch until its completion. It is high for at least the cycle before every launch, so it is released between the two transfers of a pair.
- R3: Only the byte received in the second transfer of a pair is judged; the first reply has no effect on the outcome.
- R4: If bit 2 (protocol violation) or bit 3 (fault) of a judged byte is set, the poll ends at once with done and the I/O error strobe, and that byte is shown on the status output. This takes precedence over a mask match.
- R5: A judged byte `s` with no error bit ends the poll successfully when `(s & (mask | 0x01)) == mask`, where bit 0 is busy. Success is done with neither qualifier strobe, and `s` is shown on the status output.
- R6: A mask of zero completes as soon as busy (bit 0) reads clear, whatever the other non-error bits hold.
- R7: When a judged byte neither errors nor matches and the timeout has not expired, a new sample is launched immediately. The number of samples therefore equals the number of non-terminal replies plus one.
- R8: Once TIMEOUT_CYCLES cycles have passed since the request was accepted, the next judged byte that neither errors nor matches ends the poll with done and the timeout strobe, never with the I/O error strobe. Done then arrives no earlier than TIMEOUT_CYCLES cycles after acceptance.
- R9: Done, I/O error and timeout are single-cycle strobes, and a qualifier strobe is only ever high together with done.
- R10: The request-ready output is high only while no poll is in progress. A request presented while it is low is ignored, and its mask does not affect the running poll.
- R11: After reset, request-ready is high, chip select is high, and no transfer launch or done strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a poll with req_mask (taken when req_ready is high) |
| req_mask | input | 8 | Status bits that must read set for success |
| req_ready | output | 1 | High while idle and able to accept a request |
| spi_cs_n | output | 1 | Active-low chip select to the target |
| xfer_go | output | 1 | One-cycle launch of a one-byte transfer |
| xfer_byte | output | 8 | Byte to send in the launched transfer |
| xfer_done | input | 1 | One-cycle completion of the launched transfer |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| res_done | output | 1 | One-cycle poll completion strobe |
| res_io_err | output | 1 | With res_done: an error bit was reported |
| res_timeout | output | 1 | With res_done: timeout expired before the condition was met |
| res_status | output | 8 | Last judged status byte, updated with res_done |

## Verification
The bench builds the poller with TIMEOUT_CYCLES set to 300 instead of the roughly two-second default. At that value a poll on a target that never becomes ready ends within a few hundred cycles, so a timeout outcome and its earliest allowed arrival can both be measured. The target model answers after a short fixed latency and returns an error-flagged junk byte on the first transfer of every pair. This exposes any use of the discarded reply. Each of its scripted replies is either busy, a terminal value, or a non-terminal value repeated forever.

// File: rtl/cfgpoll_pkg.sv
package cfgpoll_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_BUSY  = 0;
    localparam int BIT_READY = 1;
    localparam int BIT_VIOL  = 2;
    localparam int BIT_FAULT = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_STATUS = 8'h00;
    localparam byte_t BUSY_MASK = byte_t'(1) << BIT_BUSY;

    typedef enum logic [1:0] {
        SM_IDLE,
        SM_FIRST,
        SM_GAP,
        SM_SECOND
    } smp_state_e;

    typedef enum logic {
        PL_IDLE,
        PL_WAIT
    } poll_state_e;

    typedef enum logic [1:0] {
        OUT_AGAIN,
        OUT_OK,
        OUT_IOERR,
        OUT_TMO
    } outcome_e;

    typedef struct packed {
        logic  done;
        logic  io_err;
        logic  tmo;
        byte_t status;
    } result_t;

    function automatic logic status_faulty(byte_t s);
        return s[BIT_VIOL] | s[BIT_FAULT];
    endfunction

    function automatic logic status_met(byte_t s, byte_t m);
        return (s & (m | BUSY_MASK)) == m;
    endfunction

    function automatic outcome_e judge(byte_t s, byte_t m, logic expired);
        if (status_faulty(s))
            return OUT_IOERR;
        else if (status_met(s, m))
            return OUT_OK;
        else if (expired)
            return OUT_TMO;
        return OUT_AGAIN;
    endfunction

endpackage

// File: rtl/cfgpoll_sampler.sv
module cfgpoll_sampler
    import cfgpoll_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  cs_n,
    output logic  go,
    input  logic  done,
    input  byte_t rx,
    output logic  smp_valid,
    output byte_t smp_byte
);

    smp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SM_IDLE;
            cs_n      <= 1'b1;
            go        <= 1'b0;
            smp_valid <= 1'b0;
            smp_byte  <= '0;
        end else begin
            go        <= 1'b0;
            smp_valid <= 1'b0;
            unique case (state)
                SM_IDLE: begin
                    if (start) begin
                        state <= SM_FIRST;
                        cs_n  <= 1'b0;
                        go    <= 1'b1;
                    end
                end
                SM_FIRST: begin
                    if (done) begin
                        state <= SM_GAP;
                        cs_n  <= 1'b1;
                    end
                end
                SM_GAP: begin
                    state <= SM_SECOND;
                    cs_n  <= 1'b0;
                    go    <= 1'b1;
                end
                SM_SECOND: begin
                    if (done) begin
                        state     <= SM_IDLE;
                        cs_n      <= 1'b1;
                        smp_byte  <= rx;
                        smp_valid <= 1'b1;
                    end
                end
                default: state <= SM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgpoll_timer.sv
module cfgpoll_timer #(
    parameter int LIMIT = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    assign expired = (cnt >= LIM);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cfg_status_poller.sv
module cfg_status_poller
    import cfgpoll_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [7:0] req_mask,
    output logic       req_ready,
    output logic       spi_cs_n,
    output logic       xfer_go,
    output logic [7:0] xfer_byte,
    input  logic       xfer_done,
    input  logic [7:0] xfer_rx,
    output logic       res_done,
    output logic       res_io_err,
    output logic       res_timeout,
    output logic [7:0] res_status
);

    poll_state_e state;
    byte_t       mask_q;
    logic        smp_start;
    logic        smp_valid;
    byte_t       smp_byte;
    logic        accept;
    logic        expired;
    outcome_e    verdict;
    result_t     res_q;

    assign req_ready = (state == PL_IDLE);
    assign accept    = req_ready && req_valid;
    assign xfer_byte = OP_STATUS;
    assign verdict   = judge(smp_byte, mask_q, expired);

    cfgpoll_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .start     (smp_start),
        .cs_n      (spi_cs_n),
        .go        (xfer_go),
        .done      (xfer_done),
        .rx        (xfer_rx),
        .smp_valid (smp_valid),
        .smp_byte  (smp_byte)
    );

    cfgpoll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PL_IDLE;
            mask_q    <= '0;
            smp_start <= 1'b0;
            res_q     <= '0;
        end else begin
            smp_start    <= 1'b0;
            res_q.done   <= 1'b0;
            res_q.io_err <= 1'b0;
            res_q.tmo    <= 1'b0;
            unique case (state)
                PL_IDLE: begin
                    if (accept) begin
                        mask_q    <= req_mask;
                        smp_start <= 1'b1;
                        state     <= PL_WAIT;
                    end
                end
                PL_WAIT: begin
                    if (smp_valid) begin
                        if (verdict == OUT_AGAIN) begin
                            smp_start <= 1'b1;
                        end else begin
                            res_q.done   <= 1'b1;
                            res_q.io_err <= (verdict == OUT_IOERR);
                            res_q.tmo    <= (verdict == OUT_TMO);
                            res_q.status <= smp_byte;
                            state        <= PL_IDLE;
                        end
                    end
                end
                default: state <= PL_IDLE;
            endcase
        end
    end

    assign res_done    = res_q.done;
    assign res_io_err  = res_q.io_err;
    assign res_timeout = res_q.tmo;
    assign res_status  = res_q.status;

endmodule

// File: rtl/cfgpoll_checker.sv
module cfgpoll_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       spi_cs_n,
    input logic       xfer_go,
    input logic       xfer_done,
    input logic       res_done,
    input logic       res_io_err,
    input logic       res_timeout,
    input logic [7:0] res_status
);

    // R2: each launch follows a cycle with chip select released
    p_cs_gap_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> ($past(spi_cs_n) && !spi_cs_n));

    // R2: completions arrive while chip select is held low
    p_cs_held_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !spi_cs_n);

    // R4: an error-flagged status always carries the I/O error strobe
    p_err_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (res_done && (res_status[2] || res_status[3])) |-> res_io_err);

    // R5: a success never reports busy
    p_ok_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (res_done && !res_io_err && !res_timeout) |-> !res_status[0]);

    // R8: the two qualifiers never coincide
    p_qual_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(res_io_err && res_timeout));

    // R9: qualifiers only with done, and done lasts one cycle
    p_qual_done_r9: assert property (@(posedge clk) disable iff (rst)
        (res_io_err || res_timeout) |-> res_done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);

    // R10: an accepted request makes the block busy; done returns it to idle
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_at_done_r10: assert property (@(posedge clk) disable iff (rst)
        res_done |-> req_ready);

endmodule

bind cfg_status_poller cfgpoll_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .spi_cs_n    (spi_cs_n),
    .xfer_go     (xfer_go),
    .xfer_done   (xfer_done),
    .res_done    (res_done),
    .res_io_err  (res_io_err),
    .res_timeout (res_timeout),
    .res_status  (res_status)
);

// File: tb/cfg_status_poller_tb.sv
`timescale 1ns/1ps
module cfg_status_poller_tb;

    localparam int TMO = 300;
    localparam int LAT = 2;

    typedef struct packed {
        logic [7:0] mask;
        logic [3:0] nbusy;
        logic [7:0] fin;
        logic [1:0] kind;   // 0 ok, 1 io error, 2 timeout
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h00, 4'd0, 8'h00, 2'd0},   // R6, R3
        '{8'h02, 4'd2, 8'h02, 2'd0},   // R5, R7
        '{8'h00, 4'd3, 8'hF2, 2'd0},   // R6: other bits ignored
        '{8'h30, 4'd1, 8'h30, 2'd0},   // R5
        '{8'h00, 4'd1, 8'h04, 2'd1},   // R4 violation
        '{8'h02, 4'd0, 8'h08, 2'd1},   // R4 fault
        '{8'h02, 4'd2, 8'h06, 2'd1},   // R4 error beats match
        '{8'h02, 4'd0, 8'h00, 2'd2},   // R8 mask never set
        '{8'h30, 4'd1, 8'h10, 2'd2},   // R8 partial mask
        '{8'h00, 4'd0, 8'h01, 2'd2}    // R8 always busy
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [7:0] req_mask = 8'h00;
    logic       req_ready;
    logic       spi_cs_n;
    logic       xfer_go;
    logic [7:0] xfer_byte;
    logic       xfer_done = 1'b0;
    logic [7:0] xfer_rx = 8'h00;
    logic       res_done;
    logic       res_io_err;
    logic       res_timeout;
    logic [7:0] res_status;

    int n_checks = 0;
    int n_fail   = 0;

    // target model state
    int         scr_nbusy = 0;
    logic [7:0] scr_fin = 8'h00;
    int         n_first = 0;
    int         n_second = 0;
    bit         second_next = 0;
    bit         pend = 0;
    int         pend_cnt = 0;
    logic [7:0] pend_byte = 8'h00;
    bit         bad_opcode = 0;

    always #10 clk = ~clk;

    cfg_status_poller #(.TIMEOUT_CYCLES(TMO)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_mask    (req_mask),
        .req_ready   (req_ready),
        .spi_cs_n    (spi_cs_n),
        .xfer_go     (xfer_go),
        .xfer_byte   (xfer_byte),
        .xfer_done   (xfer_done),
        .xfer_rx     (xfer_rx),
        .res_done    (res_done),
        .res_io_err  (res_io_err),
        .res_timeout (res_timeout),
        .res_status  (res_status)
    );

    // byte-level target: first reply of each pair is junk with error bits
    always @(negedge clk) begin
        xfer_done = 1'b0;
        if (rst) begin
            pend = 0;
            second_next = 0;
        end else begin
            if (pend) begin
                if (pend_cnt == 0) begin
                    xfer_done = 1'b1;
                    xfer_rx   = pend_byte;
                    pend      = 0;
                end else begin
                    pend_cnt = pend_cnt - 1;
                end
            end
            if (xfer_go) begin
                if (xfer_byte !== 8'h00) bad_opcode = 1;
                pend     = 1;
                pend_cnt = LAT;
                if (!second_next) begin
                    pend_byte = 8'h0D;
                    n_first   = n_first + 1;
                end else begin
                    pend_byte = (n_second < scr_nbusy) ? 8'h01 : scr_fin;
                    n_second  = n_second + 1;
                end
                second_next = !second_next;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic start_poll(input logic [7:0] m, input int nb, input logic [7:0] f);
        @(negedge clk);
        scr_nbusy = nb;
        scr_fin   = f;
        n_first   = 0;
        n_second  = 0;
        req_mask  = m;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got, output int cyc,
                             output logic [2:0] fl, output logic [7:0] st);
        got = 0;
        cyc = 0;
        fl  = 3'b000;
        st  = 8'h00;
        for (int i = 0; i < 5000; i++) begin
            if (res_done) begin
                got = 1;
                fl  = {res_done, res_io_err, res_timeout};
                st  = res_status;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        if (!got) chk(1'b0, "R9", "watchdog: no done", 0, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL global watchdog expired: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit got;
        int cyc;
        logic [2:0] fl;
        logic [7:0] st;
        logic [2:0] exp_fl;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready === 1'b1, "R11", "req_ready in reset", req_ready, 1);
        chk(spi_cs_n === 1'b1, "R11", "cs_n in reset", spi_cs_n, 1);
        chk(xfer_go === 1'b0, "R11", "xfer_go in reset", xfer_go, 0);
        chk(res_done === 1'b0, "R11", "res_done in reset", res_done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && spi_cs_n === 1'b1, "R11", "idle after reset",
            {req_ready, spi_cs_n}, 3);

        // vector table (R3..R8)
        for (int v = 0; v < NV; v++) begin
            start_poll(VECS[v].mask, int'(VECS[v].nbusy), VECS[v].fin);
            wait_done(got, cyc, fl, st);
            exp_fl = (VECS[v].kind == 2'd0) ? 3'b100 :
                     (VECS[v].kind == 2'd1) ? 3'b110 : 3'b101;
            chk(fl == exp_fl, (VECS[v].kind == 2'd1) ? "R4" :
                              (VECS[v].kind == 2'd2) ? "R8" : "R5",
                "outcome flags", fl, exp_fl);
            chk(st == VECS[v].fin, "R3", "status byte", st, VECS[v].fin);
            chk(n_first == n_second, "R2", "transfer pairing", n_first, n_second);
            if (VECS[v].kind != 2'd2)
                chk(n_second == int'(VECS[v].nbusy) + 1, "R7", "sample count",
                    n_second, int'(VECS[v].nbusy) + 1);
            else
                chk(cyc >= TMO - 1 && cyc <= TMO + 40, "R8", "timeout latency",
                    cyc, TMO);
            @(negedge clk);
            chk(res_done === 1'b0 && res_io_err === 1'b0 && res_timeout === 1'b0,
                "R9", "strobes one cycle", {res_done, res_io_err, res_timeout}, 0);
        end

        // R10: request during a poll is ignored
        start_poll(8'h02, 0, 8'h00);
        repeat (20) @(negedge clk);
        chk(req_ready === 1'b0, "R10", "ready low while polling", req_ready, 0);
        req_mask  = 8'h00;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(got, cyc, fl, st);
        chk(fl == 3'b101, "R10", "mask unchanged by ignored request", fl, 3'b101);
        @(negedge clk);
        chk(req_ready === 1'b1, "R10", "ready back after done", req_ready, 1);

        // R1: opcode of every transfer
        chk(!bad_opcode, "R1", "status opcode", bad_opcode, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule